// File: doc/BRIEF.md
# UART Register Write Framer

This block sits behind a byte-level UART receiver and turns the received byte stream into register write beats. A host opens a transaction with a two-byte synchronisation marker and a 16-bit start address, then sends one or more 32-bit data words. Each complete word leaves the block as a single-cycle write strobe with its address and data. Any further word in the same transaction goes to the next address.

A quiet-time timer counts bit-time ticks since the last received byte. The limit comes from a writable gap register. Silence at a word boundary that reaches the limit closes the transaction cleanly. Silence in the middle of the address or a word aborts the frame with an error. After an abort the block enforces a quiet gap before it looks for a new marker. Bytes that arrive during that gap are rejected with an error, and each one restarts the gap.

Top module: `uart_reg_framer`

## Requirements
- R1: After reset the write strobe and error flag are low, the block is hunting for a marker, and the gap register holds 32 bit times.
- R2: A transaction opens only on byte 0x55 followed directly by 0xAA. A repeated 0x55 keeps the half-matched marker. Any other byte while hunting is discarded.
- R3: The two bytes after the marker form the start address, low byte first.
- R4: Each group of four data bytes forms one word, least significant byte first. One clock after the fourth byte, `wr_valid` pulses for exactly one cycle with `wr_addr` and `wr_data`.
- R5: Each further word in the same transaction uses the previous address plus one, wrapping from 0xFFFF to 0x0000.
- R6: When the gap-register count of ticks passes with no byte at a word boundary, the transaction closes without an error. Later bytes need a new marker.
- R7: When the gap count of ticks passes with no byte in the middle of the address or a word, `frame_err` pulses once and the partial word is dropped.
- R8: After an abort, a byte that arrives before the gap count of quiet ticks has passed produces a `frame_err` pulse. The byte is otherwise ignored and the gap count starts again.
- R9: A write on `gap_we` loads a new gap length. A byte in the same cycle as a tick restarts the quiet count, and that tick is not counted.
- R10: `wr_valid` and `frame_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per UART bit time |
| gap_we | input | 1 | Gap register write enable |
| gap_wdata | input | GAP_W (16) | New gap length in bit times |
| wr_valid | output | 1 | Write beat strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 32 | Write data |
| frame_err | output | 1 | Framing error pulse |

## Verification
The assertions hold on every cycle for these properties: a write strobe always follows a received byte and never comes in two adjacent cycles, a write strobe never coincides with an error, a byte inside the enforced gap always gives an error and never a write, and a clean close returns the block to hunting without an error. Only the bench scenarios can show that the values are right. This covers marker recognition with false starts, address and data byte order, address increment and wrap, the exact tick at which timeouts fire under the default and a programmed gap, and the effect of a byte landing on a tick.

// File: rtl/urf_pkg.sv
package urf_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int DATA_BYTES = DATA_W / 8;

    localparam logic [7:0] SYNC_FIRST  = 8'h55;
    localparam logic [7:0] SYNC_SECOND = 8'hAA;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SYNC,
        ST_ADDR,
        ST_DATA,
        ST_GAP
    } fr_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_beat_t;

    // Marker hunter step: only meaningful in ST_HUNT / ST_SYNC
    function automatic fr_state_e hunt_step(fr_state_e cur, logic [7:0] b);
        fr_state_e nxt;
        nxt = ST_HUNT;
        if (b == SYNC_FIRST)
            nxt = ST_SYNC;
        else if (cur == ST_SYNC && b == SYNC_SECOND)
            nxt = ST_ADDR;
        return nxt;
    endfunction

endpackage

// File: rtl/urf_gap_timer.sv
module urf_gap_timer #(
    parameter int GAP_W       = 16,
    parameter int DEFAULT_GAP = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [GAP_W-1:0] cfg_wdata,
    input  logic             activity,
    input  logic             tick,
    output logic             expire
);
    logic [GAP_W-1:0] gap_len;
    logic [GAP_W-1:0] quiet;
    logic [GAP_W:0]   quiet_next;

    assign quiet_next = {1'b0, quiet} + (GAP_W+1)'(1);
    assign expire     = tick && !activity && (quiet_next >= {1'b0, gap_len});

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_len <= GAP_W'(DEFAULT_GAP);
            quiet   <= '0;
        end else begin
            if (cfg_we)
                gap_len <= cfg_wdata;
            if (activity || expire)
                quiet <= '0;
            else if (tick)
                quiet <= quiet_next[GAP_W-1:0];
        end
    end
endmodule

// File: rtl/urf_byte_packer.sv
module urf_byte_packer #(
    parameter int N_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 push,
    input  logic [7:0]           byte_in,
    output logic [8*N_BYTES-1:0] word_o,
    output logic                 full_o,
    output logic                 empty_o
);
    localparam int W  = 8 * N_BYTES;
    localparam int IW = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;

    logic [W-1:0]  sr;
    logic [IW-1:0] idx;

    generate
        if (N_BYTES > 1) begin : g_multi
            assign word_o = {byte_in, sr[W-1:8]};
        end else begin : g_single
            assign word_o = byte_in;
        end
    endgenerate

    assign full_o  = push && (idx == IW'(N_BYTES-1));
    assign empty_o = (idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (push) begin
            sr  <= word_o;
            idx <= full_o ? '0 : idx + IW'(1);
        end
    end
endmodule

// File: rtl/uart_reg_framer.sv
module uart_reg_framer
    import urf_pkg::*;
#(
    parameter int GAP_W       = 16,
    parameter int DEFAULT_GAP = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              bit_tick,
    input  logic              gap_we,
    input  logic [GAP_W-1:0]  gap_wdata,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              frame_err
);
    fr_state_e         state;
    logic [ADDR_W-1:0] cur_addr;
    wr_beat_t          beat_q;
    logic              valid_q, err_q;

    logic              gap_exp;
    logic              a_push, a_full, a_empty, a_clear;
    logic              d_push, d_full, d_empty, d_clear;
    logic [ADDR_W-1:0] a_word;
    logic [DATA_W-1:0] d_word;

    urf_gap_timer #(.GAP_W(GAP_W), .DEFAULT_GAP(DEFAULT_GAP)) u_timer (
        .clk(clk), .rst(rst), .cfg_we(gap_we), .cfg_wdata(gap_wdata),
        .activity(rx_valid), .tick(bit_tick), .expire(gap_exp)
    );

    assign a_push  = rx_valid && (state == ST_ADDR);
    assign d_push  = rx_valid && (state == ST_DATA);
    assign a_clear = gap_exp && (state == ST_ADDR);
    assign d_clear = gap_exp && (state == ST_DATA);

    urf_byte_packer #(.N_BYTES(ADDR_BYTES)) u_addr_pack (
        .clk(clk), .rst(rst), .clear(a_clear), .push(a_push), .byte_in(rx_byte),
        .word_o(a_word), .full_o(a_full), .empty_o(a_empty)
    );

    urf_byte_packer #(.N_BYTES(DATA_BYTES)) u_data_pack (
        .clk(clk), .rst(rst), .clear(d_clear), .push(d_push), .byte_in(rx_byte),
        .word_o(d_word), .full_o(d_full), .empty_o(d_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_HUNT;
            cur_addr <= '0;
            beat_q   <= '0;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            if (rx_valid) begin
                unique case (state)
                    ST_HUNT, ST_SYNC: state <= hunt_step(state, rx_byte);
                    ST_ADDR: if (a_full) begin
                        cur_addr <= a_word;
                        state    <= ST_DATA;
                    end
                    ST_DATA: if (d_full) begin
                        beat_q.addr <= cur_addr;
                        beat_q.data <= d_word;
                        valid_q     <= 1'b1;
                        cur_addr    <= cur_addr + ADDR_W'(1);
                    end
                    ST_GAP:  err_q <= 1'b1;
                    default: state <= ST_HUNT;
                endcase
            end else if (gap_exp) begin
                unique case (state)
                    ST_SYNC: state <= ST_HUNT;
                    ST_ADDR: begin
                        err_q <= 1'b1;
                        state <= ST_GAP;
                    end
                    ST_DATA: begin
                        err_q <= !d_empty;
                        state <= d_empty ? ST_HUNT : ST_GAP;
                    end
                    ST_GAP:  state <= ST_HUNT;
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    assign wr_valid  = valid_q;
    assign wr_addr   = beat_q.addr;
    assign wr_data   = beat_q.data;
    assign frame_err = err_q;

endmodule

// File: rtl/uart_reg_framer_checker.sv
module uart_reg_framer_checker
    import urf_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      rx_valid,
    input logic      bit_tick,
    input logic      wr_valid,
    input logic      frame_err,
    input fr_state_e state,
    input logic      expire,
    input logic      word_empty
);
    // R4: a write beat always follows a received byte
    p_valid_after_byte_r4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(rx_valid));

    // R4: single-cycle strobe, never back to back
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R10: strobe and error are exclusive
    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && frame_err));

    // R7: an error is caused by a byte or a tick in the previous cycle
    p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $past(rx_valid || bit_tick));

    // R8: byte inside the enforced gap is flagged and produces no write
    p_gap_byte_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && rx_valid) |=> (frame_err && !wr_valid));

    // R6: timeout at a word boundary closes cleanly
    p_clean_close_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && expire && word_empty) |=> (state == ST_HUNT && !frame_err));
endmodule

bind uart_reg_framer uart_reg_framer_checker u_checker (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .bit_tick(bit_tick),
    .wr_valid(wr_valid), .frame_err(frame_err), .state(state),
    .expire(gap_exp), .word_empty(d_empty)
);

// File: tb/uart_reg_framer_test.sv
module uart_reg_framer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        bit_tick = 1'b0;
    logic        gap_we = 1'b0;
    logic [15:0] gap_wdata = 16'h0;
    logic        wr_valid, frame_err;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;

    uart_reg_framer uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .bit_tick(bit_tick), .gap_we(gap_we), .gap_wdata(gap_wdata),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_err(frame_err)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    int n_got = 0, n_err = 0, n_both = 0;
    logic [15:0] got_addr [256];
    logic [31:0] got_data [256];

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                if (n_got < 256) begin
                    got_addr[n_got] = wr_addr;
                    got_data[n_got] = wr_data;
                end
                n_got++;
            end
            if (frame_err) n_err++;
            if (wr_valid && frame_err) n_both++;
        end
    end

    function automatic logic [7:0] lane(logic [31:0] w, int k);
        return w[8*k +: 8];
    endfunction

    function automatic logic [15:0] next_addr(logic [15:0] a, int i);
        return a + 16'(i);
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic put_tick(logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b; bit_tick = 1'b1;
        @(negedge clk); rx_valid = 1'b0; bit_tick = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_gap(logic [15:0] v);
        @(negedge clk); gap_we = 1'b1; gap_wdata = v;
        @(negedge clk); gap_we = 1'b0;
    endtask

    task automatic header(logic [15:0] a);
        put(8'h55); put(8'hAA); put(a[7:0]); put(a[15:8]);
    endtask

    task automatic word(logic [31:0] w);
        for (int k = 0; k < 4; k++) put(lane(w, k));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int e0, g0;
        logic [15:0] ra [4];
        logic [31:0] rd [16];
        int          rn [4];
        void'($urandom(32'd20240611));

        idle(3);
        @(negedge clk); rst = 1'b0;
        idle(1);
        // R1: reset state
        chk(wr_valid == 1'b0, "R1 wr_valid after reset", wr_valid, 0);
        chk(frame_err == 1'b0, "R1 frame_err after reset", frame_err, 0);

        // R1/R7: default gap of 32 ticks, mid-word
        e0 = n_err;
        header(16'h0100); put(8'h01);
        ticks(31); idle(2);
        chk(n_err == e0, "R1 no error before 32 ticks", n_err - e0, 0);
        ticks(1); idle(2);
        chk(n_err == e0 + 1, "R7 error at 32nd tick", n_err - e0, 1);
        ticks(32); idle(2);

        // R2/R3/R4: false starts then a valid frame
        g0 = n_got; e0 = n_err;
        put(8'h12); put(8'hAA); put(8'h55); put(8'h13); put(8'hAA);
        put(8'h34); put(8'h12);
        put(8'h55); put(8'h55); put(8'hAA);
        put(8'h34); put(8'h12);
        word(32'h12345678);
        idle(1);
        chk(n_got == g0 + 1, "R2 one word after false starts", n_got - g0, 1);
        chk(got_addr[g0] == 16'h1234, "R3 address low byte first", got_addr[g0], 16'h1234);
        chk(got_data[g0] == 32'h12345678, "R4 little-endian data", got_data[g0], 32'h12345678);
        // R5: increment
        word(32'hDEADBEEF);
        idle(1);
        chk(got_addr[g0+1] == 16'h1235, "R5 address increment", got_addr[g0+1], 16'h1235);
        chk(got_data[g0+1] == 32'hDEADBEEF, "R4 second word", got_data[g0+1], 32'hDEADBEEF);
        // R6: clean close, later bytes need marker
        ticks(32); idle(2);
        chk(n_err == e0, "R6 clean close no error", n_err - e0, 0);
        word(32'hCAFEF00D); idle(2);
        chk(n_got == g0 + 2, "R6 no write without new marker", n_got - g0, 2);

        // R5: wrap
        g0 = n_got;
        header(16'hFFFF); word(32'hA5A5A5A5); word(32'h5A5A5A5A);
        idle(1);
        chk(got_addr[g0+1] == 16'h0000, "R5 address wrap", got_addr[g0+1], 0);
        ticks(32);

        // R9: programmed gap, byte on a tick restarts count
        set_gap(16'd4);
        e0 = n_err;
        header(16'h0010); put(8'hAB);
        ticks(3); put_tick(8'hCD); ticks(3); idle(2);
        chk(n_err == e0, "R9 byte with tick restarts count", n_err - e0, 0);
        ticks(1); idle(2);
        chk(n_err == e0 + 1, "R9 timeout at programmed gap", n_err - e0, 1);

        // R8: byte inside gap flagged and ignored
        e0 = n_err; g0 = n_got;
        ticks(3); put(8'h55); idle(1);
        chk(n_err == e0 + 1, "R8 byte in gap flagged", n_err - e0, 1);
        ticks(4);
        put(8'hAA); put(8'h20); put(8'h00); word(32'h11223344); idle(2);
        chk(n_got == g0, "R8 gap byte ignored", n_got - g0, 0);
        chk(n_err == e0 + 1, "R8 no extra errors in hunt", n_err - e0, 1);
        ticks(4);
        header(16'h0020); word(32'h11223344); idle(1);
        chk(n_got == g0 + 1 && got_data[g0] == 32'h11223344, "R8 frame accepted after gap",
            got_data[g0], 32'h11223344);
        ticks(4);

        // R4/R5 random transactions with gap 8
        set_gap(16'd8);
        e0 = n_err;
        for (int t = 0; t < 20; t++) begin
            int ng;
            g0 = n_got;
            ng = $urandom_range(0, 3);
            for (int j = 0; j < ng; j++) begin
                logic [7:0] gb;
                gb = 8'($urandom);
                if (gb == 8'h55) gb = 8'h54;
                put(gb);
            end
            ra[0] = 16'($urandom);
            rn[0] = $urandom_range(1, 4);
            for (int w = 0; w < rn[0]; w++) rd[w] = $urandom;
            put(8'h55); ticks($urandom_range(0, 6)); put(8'hAA);
            put(ra[0][7:0]); ticks($urandom_range(0, 6)); put(ra[0][15:8]);
            for (int w = 0; w < rn[0]; w++)
                for (int k = 0; k < 4; k++) begin
                    ticks($urandom_range(0, 6));
                    put(lane(rd[w], k));
                end
            idle(1);
            chk(n_got == g0 + rn[0], "R4 random word count", n_got - g0, rn[0]);
            for (int w = 0; w < rn[0]; w++) begin
                chk(got_addr[g0+w] == next_addr(ra[0], w), "R5 random address",
                    got_addr[g0+w], next_addr(ra[0], w));
                chk(got_data[g0+w] == rd[w], "R4 random data", got_data[g0+w], rd[w]);
            end
            ticks(8);
        end
        idle(2);
        chk(n_err == e0, "R6 random run free of errors", n_err - e0, 0);
        chk(n_both == 0, "R10 strobe and error never together", n_both, 0);

        summary();
    end

endmodule